// File: doc/BRIEF.md
# Pipeline Interlock Unit Without Forwarding

This block decides, every cycle, whether the instruction sitting in the decode stage of a five-stage in-order integer pipeline (fetch, decode, execute, memory, write-back) may move on to execute. The pipeline has no forwarding paths. A consumer therefore waits in decode until each older instruction that writes one of its true source registers has reached write-back. The register file writes in the first half of a cycle and reads in the second half, so a producer that is in write-back no longer blocks anything.

The unit takes the decoded fields of the decode-stage instruction: an instruction class, two source register indices and a third register index. From the class it works out which fields are actually read and which one is written. It keeps its own copy of the destination fields of the execute, memory and write-back pipeline registers. It compares the sources it reads against the pending writes in execute and memory. On a match it holds the program counter and the fetch/decode register, and it loads a bubble into execute. The bubble carries no destination and no write enable. Register 0 is never a pending destination. An overlap between destinations alone never stalls.

Top module: `hz_stall_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, `pc_we` and `ifid_we` are 1 and `ex_valid`, `ex_wen`, `me_wen` and `wb_wen` are 0.
- R2: Class codes on `id_cls` are 0 no-op, 1 register ALU, 2 immediate ALU, 3 load, 4 store, 5 two-register branch, 6 jump, 7 upper-immediate. Class 1 writes `id_rd`. Classes 2, 3 and 7 write `id_rt`. Classes 0, 4, 5 and 6 write nothing. An instruction that writes nothing never causes a later instruction to stall. When an instruction enters execute, `ex_valid` is 1, and `ex_wen`/`ex_dst` show that destination.
- R3: An instruction in decode that reads a register written by an older instruction still in execute or memory stalls. It enters execute in the cycle after the producer's write-back cycle, three cycles after the producer entered execute. This holds for ALU producers followed directly by the consumer.
- R4: A load followed directly by an instruction that reads the load's destination gives the consumer three cycles in decode. The consumer enters execute two cycles later than it would with no hazard.
- R5: A producer three or more instructions ahead of the consumer causes no stall.
- R6: An instruction whose destination field equals a pending destination, but which does not read that register, does not stall. This includes a load whose `id_rt` matches an older write.
- R7: A store reads `id_rt` as its data, and it stalls on a pending write to that register exactly as it does for `id_rs`.
- R8: Register 0 never causes a stall, and `ex_wen`, `me_wen` and `wb_wen` are never 1 with a destination of 0.
- R9: In a stall cycle `pc_we` and `ifid_we` are both 0. In the next cycle `ex_valid` and `ex_wen` are 0.
- R10: Source use: class 1, 4 and 5 read `id_rs` and `id_rt`; classes 2 and 3 read only `id_rs`; classes 0, 6 and 7 read nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_valid | input | 1 | Decode stage holds an instruction |
| id_cls | input | 3 | Instruction class of the decode-stage instruction |
| id_rs | input | 5 | First source register index |
| id_rt | input | 5 | Second source, or destination for immediate forms |
| id_rd | input | 5 | Destination for register ALU form |
| pc_we | output | 1 | Program counter write enable (0 while stalling) |
| ifid_we | output | 1 | Fetch/decode register write enable (0 while stalling) |
| ex_valid | output | 1 | Execute stage holds an instruction (0 for a bubble) |
| ex_wen | output | 1 | Execute stage instruction will write a register |
| ex_dst | output | 5 | Execute stage destination index |
| me_valid | output | 1 | Memory stage holds an instruction |
| me_wen | output | 1 | Memory stage instruction will write a register |
| me_dst | output | 5 | Memory stage destination index |
| wb_valid | output | 1 | Write-back stage holds an instruction |
| wb_wen | output | 1 | Register file write enable |
| wb_dst | output | 5 | Register file write index |

## Verification
Suppose a pending-destination entry were wrong, for example a lost write enable or a stale index. The effect would appear at the ports within one or two cycles. It shows as an early entry into execute for a dependent instruction (a missing `ifid_we` low cycle), as an extra stall for an independent one, or as a wrong `ex_dst`/`wb_dst` on the next edge. The sweep places every producer class in front of every consumer class at distances one to three. The register patterns cover a source read through each field, a destination-only overlap and register 0. Each case measures the gap between execute entries against the arithmetic rule. Each cycle it also checks the bubble and the destination fields that enter execute.

// File: rtl/hz_pkg.sv
package hz_pkg;
    localparam int RIDX_W = 5;

    typedef enum logic [2:0] {
        CLS_NOP    = 3'd0,
        CLS_RTYPE  = 3'd1,
        CLS_IALU   = 3'd2,
        CLS_LOAD   = 3'd3,
        CLS_STORE  = 3'd4,
        CLS_BRANCH = 3'd5,
        CLS_JUMP   = 3'd6,
        CLS_LUI    = 3'd7
    } cls_e;

    typedef struct packed {
        logic              valid;
        logic              wen;
        logic [RIDX_W-1:0] idx;
    } dst_t;

    localparam dst_t DST_BUBBLE = '{valid: 1'b0, wen: 1'b0, idx: '0};
endpackage

// File: rtl/hz_srcdec.sv
module hz_srcdec
    import hz_pkg::*;
(
    input  cls_e              cls,
    input  logic [RIDX_W-1:0] rt,
    input  logic [RIDX_W-1:0] rd,
    output logic              use_rs,
    output logic              use_rt,
    output logic              wr_en,
    output logic [RIDX_W-1:0] wr_idx
);
    logic              has_dst;
    logic [RIDX_W-1:0] sel_idx;

    always_comb begin
        use_rs  = 1'b0;
        use_rt  = 1'b0;
        has_dst = 1'b0;
        sel_idx = '0;
        unique case (cls)
            CLS_RTYPE: begin
                use_rs  = 1'b1;
                use_rt  = 1'b1;
                has_dst = 1'b1;
                sel_idx = rd;
            end
            CLS_IALU, CLS_LOAD: begin
                use_rs  = 1'b1;
                has_dst = 1'b1;
                sel_idx = rt;
            end
            CLS_STORE, CLS_BRANCH: begin
                use_rs  = 1'b1;
                use_rt  = 1'b1;
            end
            CLS_LUI: begin
                has_dst = 1'b1;
                sel_idx = rt;
            end
            default: begin
            end
        endcase
        // Register 0 is never a real destination
        wr_en  = has_dst && (sel_idx != '0);
        wr_idx = wr_en ? sel_idx : '0;
    end

    // R10: a class that reads nothing must not raise a use flag
    always_comb begin
        if (cls == CLS_JUMP || cls == CLS_LUI || cls == CLS_NOP)
            a_r10_no_reads: assert (!use_rs && !use_rt);
    end
endmodule

// File: rtl/hz_match.sv
module hz_match
    import hz_pkg::*;
#(
    parameter int NUM_PEND = 2
) (
    input  logic                     use_rs,
    input  logic                     use_rt,
    input  logic [RIDX_W-1:0]        rs,
    input  logic [RIDX_W-1:0]        rt,
    input  dst_t [NUM_PEND-1:0]      pend,
    output logic                     hit
);
    logic [NUM_PEND-1:0] hit_v;
    logic                rs_live;
    logic                rt_live;

    assign rs_live = use_rs && (rs != '0);
    assign rt_live = use_rt && (rt != '0);

    for (genvar i = 0; i < NUM_PEND; i++) begin : g_cmp
        logic pend_live;
        assign pend_live = pend[i].valid && pend[i].wen;
        assign hit_v[i]  = pend_live &&
                           ((rs_live && (rs == pend[i].idx)) ||
                            (rt_live && (rt == pend[i].idx)));
    end

    assign hit = |hit_v;

    // R8: a hit always names a nonzero register
    always_comb begin
        if (hit)
            a_r8_hit_nonzero: assert (rs_live || rt_live);
    end
endmodule

// File: rtl/hz_dstpipe.sv
module hz_dstpipe
    import hz_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  dst_t              ins,
    output dst_t [DEPTH-1:0]  stg
);
    typedef struct packed {
        dst_t [DEPTH-1:0] st;
    } pipe_s;

    pipe_s pipe_d, pipe_q;

    always_comb begin
        pipe_d       = pipe_q;
        pipe_d.st[0] = ins;
        for (int k = 1; k < DEPTH; k++) begin
            pipe_d.st[k] = pipe_q.st[k-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign stg = pipe_q.st;

    for (genvar k = 0; k < DEPTH; k++) begin : g_chk
        // R8: no stage ever holds a write to register 0
        a_r8_no_zero_pending: assert property (@(posedge clk) disable iff (!rst_n)
            stg[k].wen |-> (stg[k].idx != '0 && stg[k].valid));
    end

    for (genvar k = 1; k < DEPTH; k++) begin : g_adv
        // R5: a write moves one stage per cycle toward write-back
        a_r5_advance: assert property (@(posedge clk) disable iff (!rst_n)
            stg[k-1].wen |=> (stg[k].wen && stg[k].idx == $past(stg[k-1].idx)));
    end
endmodule

// File: rtl/hz_stall_unit.sv
module hz_stall_unit
    import hz_pkg::*;
#(
    parameter int PIPE_DEPTH = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       id_valid,
    input  logic [2:0] id_cls,
    input  logic [4:0] id_rs,
    input  logic [4:0] id_rt,
    input  logic [4:0] id_rd,
    output logic       pc_we,
    output logic       ifid_we,
    output logic       ex_valid,
    output logic       ex_wen,
    output logic [4:0] ex_dst,
    output logic       me_valid,
    output logic       me_wen,
    output logic [4:0] me_dst,
    output logic       wb_valid,
    output logic       wb_wen,
    output logic [4:0] wb_dst
);
    // Stages ahead of write-back still hold unwritten results
    localparam int NUM_PEND = PIPE_DEPTH - 1;

    cls_e              cls;
    logic              use_rs, use_rt;
    logic              wr_en;
    logic [RIDX_W-1:0] wr_idx;
    logic              hit;
    logic              stall;
    dst_t              ins;
    dst_t [PIPE_DEPTH-1:0] stg;

    assign cls = cls_e'(id_cls);

    hz_srcdec u_dec (
        .cls    (cls),
        .rt     (id_rt),
        .rd     (id_rd),
        .use_rs (use_rs),
        .use_rt (use_rt),
        .wr_en  (wr_en),
        .wr_idx (wr_idx)
    );

    hz_match #(.NUM_PEND(NUM_PEND)) u_match (
        .use_rs (use_rs),
        .use_rt (use_rt),
        .rs     (id_rs),
        .rt     (id_rt),
        .pend   (stg[NUM_PEND-1:0]),
        .hit    (hit)
    );

    always_comb begin
        stall = id_valid && hit;
        if (stall) begin
            ins = DST_BUBBLE;
        end else begin
            ins.valid = id_valid;
            ins.wen   = id_valid && wr_en;
            ins.idx   = (id_valid && wr_en) ? wr_idx : '0;
        end
    end

    hz_dstpipe #(.DEPTH(PIPE_DEPTH)) u_pipe (
        .clk   (clk),
        .rst_n (rst_n),
        .ins   (ins),
        .stg   (stg)
    );

    assign pc_we    = !stall;
    assign ifid_we  = !stall;
    assign ex_valid = stg[0].valid;
    assign ex_wen   = stg[0].wen;
    assign ex_dst   = stg[0].idx;
    assign me_valid = stg[1].valid;
    assign me_wen   = stg[1].wen;
    assign me_dst   = stg[1].idx;
    assign wb_valid = stg[PIPE_DEPTH-1].valid;
    assign wb_wen   = stg[PIPE_DEPTH-1].wen;
    assign wb_dst   = stg[PIPE_DEPTH-1].idx;

    // R9: a held decode stage is followed by a bubble in execute
    a_r9_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        !ifid_we |=> (!ex_valid && !ex_wen));

    // R3: a stall needs an instruction in decode
    a_r3_stall_needs_insn: assert property (@(posedge clk) disable iff (!rst_n)
        !ifid_we |-> id_valid);

    // R5: nothing in execute or memory means no stall
    a_r5_empty_front_free: assert property (@(posedge clk) disable iff (!rst_n)
        (!ex_wen && !me_wen) |-> ifid_we);
endmodule

// File: tb/tb_hz_stall_unit.sv
`timescale 1ns/1ps
module tb_hz_stall_unit;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       id_valid;
    logic [2:0] id_cls;
    logic [4:0] id_rs, id_rt, id_rd;
    logic       pc_we, ifid_we;
    logic       ex_valid, ex_wen;
    logic [4:0] ex_dst;
    logic       me_valid, me_wen;
    logic [4:0] me_dst;
    logic       wb_valid, wb_wen;
    logic [4:0] wb_dst;

    always #2.5 clk = ~clk;

    hz_stall_unit dut (
        .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_cls(id_cls),
        .id_rs(id_rs), .id_rt(id_rt), .id_rd(id_rd),
        .pc_we(pc_we), .ifid_we(ifid_we),
        .ex_valid(ex_valid), .ex_wen(ex_wen), .ex_dst(ex_dst),
        .me_valid(me_valid), .me_wen(me_wen), .me_dst(me_dst),
        .wb_valid(wb_valid), .wb_wen(wb_wen), .wb_dst(wb_dst)
    );

    int n_run  = 0;
    int n_fail = 0;
    int cyc    = 0;

    logic [2:0] p_cls [8];
    logic [4:0] p_rs  [8];
    logic [4:0] p_rt  [8];
    logic [4:0] p_rd  [8];
    int         ent   [8];
    int         plen;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit writes(input logic [2:0] c);
        return (c == 3'd1) || (c == 3'd2) || (c == 3'd3) || (c == 3'd7);
    endfunction

    function automatic logic [4:0] dst_of(input logic [2:0] c,
                                          input logic [4:0] rt, input logic [4:0] rd);
        if (c == 3'd1) return rd;
        if (writes(c)) return rt;
        return 5'd0;
    endfunction

    function automatic bit reads_rs(input logic [2:0] c);
        return (c >= 3'd1) && (c <= 3'd5);
    endfunction

    function automatic bit reads_rt(input logic [2:0] c);
        return (c == 3'd1) || (c == 3'd4) || (c == 3'd5);
    endfunction

    task automatic set_slot(input int i, input logic [2:0] c, input logic [4:0] rs,
                            input logic [4:0] rt, input logic [4:0] rd);
        p_cls[i] = c; p_rs[i] = rs; p_rt[i] = rt; p_rd[i] = rd;
    endtask

    task automatic run_prog();
        int  idx = 0;
        bit  adv;
        bit  exp_wen;
        logic [4:0] exp_dst;
        while (idx < plen) begin
            id_valid = 1'b1;
            id_cls = p_cls[idx]; id_rs = p_rs[idx];
            id_rt = p_rt[idx];   id_rd = p_rd[idx];
            #1;
            chk(pc_we == ifid_we, "R9", "pc_we vs ifid_we", pc_we, ifid_we);
            adv = ifid_we;
            exp_dst = dst_of(p_cls[idx], p_rt[idx], p_rd[idx]);
            exp_wen = (exp_dst != 5'd0);
            if (adv) ent[idx] = cyc + 1;
            @(posedge clk); #1;
            cyc++;
            if (!adv) begin
                chk(!ex_valid && !ex_wen, "R9", "bubble valid/wen",
                    {ex_valid, ex_wen}, 0);
            end else begin
                chk(ex_valid && ex_wen == exp_wen, "R2", "ex valid/wen",
                    {ex_valid, ex_wen}, {1'b1, exp_wen});
                if (exp_wen)
                    chk(ex_dst == exp_dst, "R2", "ex_dst", ex_dst, exp_dst);
                else
                    chk(!(ex_wen && ex_dst == 5'd0), "R8", "zero write", ex_dst, 0);
                idx++;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; id_valid = 1'b0; id_cls = 3'd0;
        id_rs = 5'd0; id_rt = 5'd0; id_rd = 5'd0;
        repeat (2) @(posedge clk);
        #1;
        chk(pc_we && ifid_we, "R1", "front enables in reset", {pc_we, ifid_we}, 3);
        chk(!ex_valid && !ex_wen && !me_wen && !wb_wen, "R1", "empty stages in reset",
            {ex_valid, ex_wen, me_wen, wb_wen}, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk(pc_we && ifid_we, "R1", "front enables after reset", {pc_we, ifid_we}, 3);
        chk(!ex_valid && !ex_wen && !wb_wen, "R1", "empty stages after reset",
            {ex_valid, ex_wen, wb_wen}, 0);

        for (int pc = 0; pc < 8; pc++) begin
            for (int cc = 0; cc < 8; cc++) begin
                for (int d = 1; d <= 3; d++) begin
                    for (int pat = 0; pat < 4; pat++) begin
                        logic [4:0] t;
                        logic [4:0] crs, crt, crd;
                        bit   haz;
                        int   gap, exp_gap;
                        string tag;
                        t = (pat == 3) ? 5'd0 : 5'd5;
                        case (pat)
                            0: begin crs = t;    crt = 5'd9;  crd = 5'd10; end
                            1: begin crs = 5'd9; crt = t;     crd = 5'd10; end
                            2: begin crs = 5'd9; crt = 5'd10; crd = t;     end
                            default: begin crs = 5'd0; crt = 5'd0; crd = 5'd0; end
                        endcase
                        plen = 0;
                        set_slot(plen, pc[2:0], 5'd8, t, t); plen++;
                        for (int f = 1; f < d; f++) begin
                            set_slot(plen, 3'd0, 5'd0, 5'd0, 5'd0); plen++;
                        end
                        set_slot(plen, cc[2:0], crs, crt, crd); plen++;
                        for (int f = 0; f < 3; f++) begin
                            set_slot(plen, 3'd0, 5'd0, 5'd0, 5'd0); plen++;
                        end
                        run_prog();
                        haz = writes(pc[2:0]) && (t != 5'd0) &&
                              ((reads_rs(cc[2:0]) && crs == t) ||
                               (reads_rt(cc[2:0]) && crt == t));
                        exp_gap = (haz && d < 3) ? 3 : d;
                        gap = ent[d] - ent[0];
                        if (pat == 3)                        tag = "R8";
                        else if (!writes(pc[2:0]))           tag = "R2";
                        else if (!haz && pat == 2)           tag = "R6";
                        else if (!haz && cc == 3 && pat == 1) tag = "R6";
                        else if (!haz)                       tag = "R10";
                        else if (d >= 3)                     tag = "R5";
                        else if (cc == 4 && pat == 1)        tag = "R7";
                        else if (pc == 3 && d == 1)          tag = "R4";
                        else                                 tag = "R3";
                        chk(gap == exp_gap, tag, $sformatf("EX gap p%0d c%0d d%0d pat%0d",
                            pc, cc, d, pat), gap, exp_gap);
                    end
                end
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule